// File: doc/BRIEF.md
# Multicycle 32-bit Integer Core

This block is a small 32-bit processor core for an integer instruction subset: word load and store, register-register add, subtract, and, or and signed set-less-than, add-immediate, branch-if-equal, jump, and jump-and-link. A state-machine controller takes each instruction through a sequence of short clock steps. The same ALU and one memory port serve every step. Holding registers carry values from one step to the next: the instruction register, the memory data register, the two operand registers and the ALU result register.

The core drives one single-port memory bus. A multiplexer chooses the bus address, either the program counter (instruction fetch) or the ALU result register (data access). Read data must be valid combinationally in the cycle the address is presented. There is no valid/ready handshake and no back-pressure. Each bus cycle completes in the cycle its strobe is high, so the memory cannot stall the core. Instructions take between two and five cycles, depending on the opcode.

Top module: `mc_core`

## Requirements
- R1: While reset is held and in the first cycle after it, the core is in the fetch step with PC = 0. The bus shows a read strobe at address 0 and no write strobe.
- R2: Every instruction starts with one fetch cycle: a read at address PC. The word is taken as the instruction and PC advances by 4 at the end of that cycle.
- R3: Instruction lengths in cycles are: load 5, store 4, register-register 4, add-immediate 4, branch 3, jump 3, jump-and-link 3. Opcodes (bits 31:26) are: load 0x23, store 0x2B, register-register 0x00, add-immediate 0x08, branch 0x04, jump 0x02, jump-and-link 0x03.
- R4: A load reads memory in its fourth cycle at rs + sign-extended imm16 (rs bits 25:21, imm bits 15:0). The word read is written to rt (bits 20:16).
- R5: A store drives a write strobe in its fourth cycle, and no read strobe. The address is rs + sign-extended imm16 and the write data is the value of rt.
- R6: A register-register instruction applies the operation chosen by funct (bits 5:0) to rs and rt, and writes the result to rd (bits 15:11). The codes are 0x20 add, 0x22 subtract, 0x24 and, 0x25 or, 0x2A signed less-than, which gives 1 or 0.
- R7: Add-immediate writes rs + sign-extended imm16 to rt.
- R8: A branch compares rs with rt. When they are equal, PC becomes PC+4 + (sign-extended imm16 << 2). Otherwise execution falls through to PC+4.
- R9: Jump and jump-and-link set PC to {upper 4 bits of PC+4, bits 25:0, 2'b00}. Jump-and-link also writes PC+4 to register 31.
- R10: Register 0 always reads as zero, and writes to it have no effect.
- R11: An unrecognised opcode, or a register-register funct outside R6, takes 2 cycles. It changes no register, no memory and no PC beyond the fetch increment.
- R12: The read and write strobes are never high in the same cycle, and every store cycle is followed by a fetch read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Asynchronous reset, active high |
| mem_addr | output | 32 | Byte address of the current bus cycle |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Read data, valid in the same cycle as the address |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe, memory writes on the rising edge |

## Verification
The address and strobes on the bus expose a wrong controller state or a wrong PC in the same cycle. A lost step or an extra step moves the next fetch away from the expected cycle, and a bad PC puts the wrong fetch address on the bus at once. A register or holding-register value that has gone wrong stays invisible until it is used. It then shows as a wrong load or store address, or as wrong store data, at the next memory instruction. For that reason the program stores every result it computes, and the bus is compared with an instruction-level model on every clock.

// File: rtl/mc_pkg.sv
package mc_pkg;
  localparam int XLEN = 32;
  localparam int OPW  = 6;

  localparam logic [OPW-1:0] OP_RTYPE = 6'h00;
  localparam logic [OPW-1:0] OP_J     = 6'h02;
  localparam logic [OPW-1:0] OP_JAL   = 6'h03;
  localparam logic [OPW-1:0] OP_BEQ   = 6'h04;
  localparam logic [OPW-1:0] OP_ADDI  = 6'h08;
  localparam logic [OPW-1:0] OP_LW    = 6'h23;
  localparam logic [OPW-1:0] OP_SW    = 6'h2b;

  localparam logic [OPW-1:0] FN_ADD = 6'h20;
  localparam logic [OPW-1:0] FN_SUB = 6'h22;
  localparam logic [OPW-1:0] FN_AND = 6'h24;
  localparam logic [OPW-1:0] FN_OR  = 6'h25;
  localparam logic [OPW-1:0] FN_SLT = 6'h2a;

  typedef enum logic [3:0] {
    ST_FETCH, ST_DECODE, ST_MADDR, ST_MRD, ST_MWB, ST_MWR,
    ST_REXE, ST_RWB, ST_IEXE, ST_IWB, ST_BEQ, ST_JMP, ST_JAL
  } state_e;

  typedef enum logic [2:0] {ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT} alu_op_e;
  typedef enum logic [1:0] {PCS_ALU, PCS_OUT, PCS_JMP} pc_src_e;
  typedef enum logic [1:0] {SRCB_REG, SRCB_FOUR, SRCB_IMM, SRCB_BOFF} srcb_e;
  typedef enum logic [1:0] {DST_RT, DST_RD, DST_LINK} dst_e;
  typedef enum logic [1:0] {WD_ALU, WD_MEM, WD_PC} wd_e;

  typedef struct packed {
    logic    pc_we;
    logic    pc_cond;
    pc_src_e pc_src;
    logic    iord;
    logic    mem_rd;
    logic    mem_wr;
    logic    ir_we;
    logic    ab_we;
    logic    out_we;
    logic    mdr_we;
    logic    rf_we;
    dst_e    dst;
    wd_e     wd;
    logic    srca_reg;
    srcb_e   srcb;
    alu_op_e alu_op;
  } ctrl_t;
endpackage

// File: rtl/mc_regfile.sv
module mc_regfile import mc_pkg::*; #(
  parameter int NREG = 32,
  localparam int RAW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [RAW-1:0]  ra1,
  input  logic [RAW-1:0]  ra2,
  output logic [XLEN-1:0] rd1,
  output logic [XLEN-1:0] rd2,
  input  logic            we,
  input  logic [RAW-1:0]  waddr,
  input  logic [XLEN-1:0] wdata
);
  logic [XLEN-1:0] rvec [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (i == 0) begin : g_zero
      assign rvec[i] = '0;
    end else begin : g_live
      logic [XLEN-1:0] q;
      always_ff @(posedge clk or posedge rst) begin
        if (rst)                            q <= '0;
        else if (we && waddr == RAW'(i))    q <= wdata;
      end
      assign rvec[i] = q;
    end
  end

  assign rd1 = rvec[ra1];
  assign rd2 = rvec[ra2];
endmodule

// File: rtl/mc_alu.sv
module mc_alu import mc_pkg::*; (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  alu_op_e         op,
  output logic [XLEN-1:0] y,
  output logic            zero
);
  always_comb begin
    unique case (op)
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_SLT: y = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = a + b;
    endcase
  end
  assign zero = (y == '0);
endmodule

// File: rtl/mc_ctrl.sv
module mc_ctrl import mc_pkg::*; (
  input  logic           clk,
  input  logic           rst,
  input  logic [OPW-1:0] opcode,
  input  logic [OPW-1:0] funct,
  output state_e         state,
  output ctrl_t          ctl
);
  state_e state_q, state_d;

  function automatic logic funct_known(input logic [OPW-1:0] f);
    return (f == FN_ADD) || (f == FN_SUB) || (f == FN_AND) ||
           (f == FN_OR)  || (f == FN_SLT);
  endfunction

  function automatic alu_op_e funct_op(input logic [OPW-1:0] f);
    case (f)
      FN_SUB:  return ALU_SUB;
      FN_AND:  return ALU_AND;
      FN_OR:   return ALU_OR;
      FN_SLT:  return ALU_SLT;
      default: return ALU_ADD;
    endcase
  endfunction

  always_ff @(posedge clk or posedge rst) begin
    if (rst) state_q <= ST_FETCH;
    else     state_q <= state_d;
  end

  always_comb begin
    state_d = ST_FETCH;
    case (state_q)
      ST_FETCH:  state_d = ST_DECODE;
      ST_DECODE: begin
        case (opcode)
          OP_LW, OP_SW: state_d = ST_MADDR;
          OP_RTYPE:     state_d = funct_known(funct) ? ST_REXE : ST_FETCH;
          OP_ADDI:      state_d = ST_IEXE;
          OP_BEQ:       state_d = ST_BEQ;
          OP_J:         state_d = ST_JMP;
          OP_JAL:       state_d = ST_JAL;
          default:      state_d = ST_FETCH;
        endcase
      end
      ST_MADDR: state_d = (opcode == OP_LW) ? ST_MRD : ST_MWR;
      ST_MRD:   state_d = ST_MWB;
      ST_REXE:  state_d = ST_RWB;
      ST_IEXE:  state_d = ST_IWB;
      default:  state_d = ST_FETCH;
    endcase
  end

  always_comb begin
    ctl          = '0;
    ctl.pc_src   = PCS_ALU;
    ctl.dst      = DST_RT;
    ctl.wd       = WD_ALU;
    ctl.srcb     = SRCB_REG;
    ctl.alu_op   = ALU_ADD;
    case (state_q)
      ST_FETCH: begin
        ctl.mem_rd = 1'b1;
        ctl.ir_we  = 1'b1;
        ctl.srcb   = SRCB_FOUR;
        ctl.pc_we  = 1'b1;
      end
      ST_DECODE: begin
        ctl.ab_we  = 1'b1;
        ctl.out_we = 1'b1;
        ctl.srcb   = SRCB_BOFF;
      end
      ST_MADDR, ST_IEXE: begin
        ctl.out_we   = 1'b1;
        ctl.srca_reg = 1'b1;
        ctl.srcb     = SRCB_IMM;
      end
      ST_MRD: begin
        ctl.mem_rd = 1'b1;
        ctl.iord   = 1'b1;
        ctl.mdr_we = 1'b1;
      end
      ST_MWB: begin
        ctl.rf_we = 1'b1;
        ctl.wd    = WD_MEM;
      end
      ST_MWR: begin
        ctl.mem_wr = 1'b1;
        ctl.iord   = 1'b1;
      end
      ST_REXE: begin
        ctl.out_we   = 1'b1;
        ctl.srca_reg = 1'b1;
        ctl.alu_op   = funct_op(funct);
      end
      ST_RWB: begin
        ctl.rf_we = 1'b1;
        ctl.dst   = DST_RD;
      end
      ST_IWB: ctl.rf_we = 1'b1;
      ST_BEQ: begin
        ctl.srca_reg = 1'b1;
        ctl.alu_op   = ALU_SUB;
        ctl.pc_cond  = 1'b1;
        ctl.pc_src   = PCS_OUT;
      end
      ST_JMP: begin
        ctl.pc_we  = 1'b1;
        ctl.pc_src = PCS_JMP;
      end
      ST_JAL: begin
        ctl.pc_we  = 1'b1;
        ctl.pc_src = PCS_JMP;
        ctl.rf_we  = 1'b1;
        ctl.dst    = DST_LINK;
        ctl.wd     = WD_PC;
      end
      default: ;
    endcase
  end

  assign state = state_q;
endmodule

// File: rtl/mc_core.sv
module mc_core import mc_pkg::*; #(
  parameter int NREG = 32,
  localparam int RAW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  output logic [XLEN-1:0] mem_addr,
  output logic [XLEN-1:0] mem_wdata,
  input  logic [XLEN-1:0] mem_rdata,
  output logic            mem_rd,
  output logic            mem_wr
);
  localparam logic [RAW-1:0] LINK_REG = RAW'(NREG - 1);

  state_e          state_q;
  ctrl_t           ctl;
  logic [XLEN-1:0] pc_q, ir_q, mdr_q, a_q, b_q, out_q;
  logic [XLEN-1:0] rf_rd1, rf_rd2, rf_wdata, pc_next;
  logic [XLEN-1:0] alu_a, alu_b, alu_y, imm_sx, jtarget;
  logic [RAW-1:0]  rf_waddr;
  logic            alu_zero, pc_load;

  mc_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .opcode (ir_q[31:26]),
    .funct  (ir_q[5:0]),
    .state  (state_q),
    .ctl    (ctl)
  );

  mc_regfile #(.NREG(NREG)) u_rf (
    .clk   (clk),
    .rst   (rst),
    .ra1   (ir_q[21 +: RAW]),
    .ra2   (ir_q[16 +: RAW]),
    .rd1   (rf_rd1),
    .rd2   (rf_rd2),
    .we    (ctl.rf_we),
    .waddr (rf_waddr),
    .wdata (rf_wdata)
  );

  mc_alu u_alu (
    .a    (alu_a),
    .b    (alu_b),
    .op   (ctl.alu_op),
    .y    (alu_y),
    .zero (alu_zero)
  );

  assign imm_sx  = {{(XLEN-16){ir_q[15]}}, ir_q[15:0]};
  assign jtarget = {pc_q[XLEN-1:XLEN-4], ir_q[25:0], 2'b00};

  assign alu_a = ctl.srca_reg ? a_q : pc_q;

  always_comb begin
    case (ctl.srcb)
      SRCB_FOUR: alu_b = XLEN'(4);
      SRCB_IMM:  alu_b = imm_sx;
      SRCB_BOFF: alu_b = {imm_sx[XLEN-3:0], 2'b00};
      default:   alu_b = b_q;
    endcase
  end

  always_comb begin
    case (ctl.dst)
      DST_RD:   rf_waddr = ir_q[11 +: RAW];
      DST_LINK: rf_waddr = LINK_REG;
      default:  rf_waddr = ir_q[16 +: RAW];
    endcase
  end

  always_comb begin
    case (ctl.wd)
      WD_MEM:  rf_wdata = mdr_q;
      WD_PC:   rf_wdata = pc_q;
      default: rf_wdata = out_q;
    endcase
  end

  always_comb begin
    case (ctl.pc_src)
      PCS_OUT: pc_next = out_q;
      PCS_JMP: pc_next = jtarget;
      default: pc_next = alu_y;
    endcase
  end

  assign pc_load = ctl.pc_we | (ctl.pc_cond & alu_zero);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      pc_q  <= '0;
      ir_q  <= '0;
      mdr_q <= '0;
      a_q   <= '0;
      b_q   <= '0;
      out_q <= '0;
    end else begin
      if (pc_load)    pc_q  <= pc_next;
      if (ctl.ir_we)  ir_q  <= mem_rdata;
      if (ctl.mdr_we) mdr_q <= mem_rdata;
      if (ctl.ab_we) begin
        a_q <= rf_rd1;
        b_q <= rf_rd2;
      end
      if (ctl.out_we) out_q <= alu_y;
    end
  end

  assign mem_addr  = ctl.iord ? out_q : pc_q;
  assign mem_wdata = b_q;
  assign mem_rd    = ctl.mem_rd;
  assign mem_wr    = ctl.mem_wr;
endmodule

// File: rtl/mc_core_chk.sv
module mc_core_chk import mc_pkg::*; (
  input logic            clk,
  input logic            rst,
  input logic            mem_rd,
  input logic            mem_wr,
  input logic [XLEN-1:0] mem_rdata,
  input state_e          state,
  input logic [XLEN-1:0] pc,
  input logic [XLEN-1:0] ir,
  input logic [XLEN-1:0] a,
  input logic [XLEN-1:0] mdr
);
  a_r12_strobe_excl: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  a_r12_store_then_fetch: assert property (@(posedge clk) disable iff (rst)
    mem_wr |=> (mem_rd && state == ST_FETCH));

  a_r2_pc_advance: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FETCH) |=> (pc == $past(pc) + 32'd4));

  a_r3_fetch_to_decode: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FETCH) |=> (state == ST_DECODE));

  a_r4_mdr_capture: assert property (@(posedge clk) disable iff (rst)
    (state == ST_MRD) |=> (mdr == $past(mem_rdata)));

  a_r10_r0_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DECODE && ir[25:21] == 5'd0) |=> (a == '0));

  a_r11_bad_opcode: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DECODE && ir[31:26] == 6'h3f) |=> (state == ST_FETCH && pc == $past(pc)));
endmodule

bind mc_core mc_core_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .mem_rd    (mem_rd),
  .mem_wr    (mem_wr),
  .mem_rdata (mem_rdata),
  .state     (state_q),
  .pc        (pc_q),
  .ir        (ir_q),
  .a         (a_q),
  .mdr       (mdr_q)
);

// File: tb/mc_core_tb_top.sv
module mc_core_tb_top;
  localparam int RUN_CYCLES = 240;

  logic        clk = 1'b0;
  logic        rst = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_rd, mem_wr;

  logic [31:0] mem  [256];
  logic [31:0] mmem [256];
  logic [31:0] mreg [32];
  logic [31:0] mpc;
  logic [31:0] cur;
  int          k, ilen_cur;
  int          n_tests = 0, n_fail = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  mc_core dut_i (
    .clk       (clk),
    .rst       (rst),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr)
  );

  function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs,
                                        input logic [4:0] rt, input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction
  function automatic logic [31:0] enc_r(input logic [4:0] rs, input logic [4:0] rt,
                                        input logic [4:0] rd, input logic [5:0] fn);
    return {6'h00, rs, rt, rd, 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_j(input logic [5:0] op, input logic [25:0] idx);
    return {op, idx};
  endfunction

  function automatic logic [31:0] prog_word(input int i);
    case (i)
      0:  return enc_i(6'h08, 0, 1, 16'd7);
      1:  return enc_i(6'h08, 0, 2, 16'hFFFD);
      2:  return enc_r(1, 2, 3, 6'h20);
      3:  return enc_r(2, 1, 4, 6'h22);
      4:  return enc_r(1, 2, 5, 6'h24);
      5:  return enc_r(1, 2, 6, 6'h25);
      6:  return enc_r(2, 1, 7, 6'h2a);
      7:  return enc_r(1, 2, 8, 6'h2a);
      8:  return enc_i(6'h2b, 0, 3, 16'h0200);
      9:  return enc_i(6'h23, 0, 9, 16'h0200);
      10: return enc_i(6'h08, 0, 0, 16'd5);
      11: return enc_i(6'h2b, 0, 0, 16'h0204);
      12: return enc_i(6'h04, 1, 2, 16'd5);
      13: return enc_i(6'h04, 9, 3, 16'd1);
      14: return enc_i(6'h08, 0, 10, 16'd99);
      15: return enc_j(6'h03, 26'd18);
      16: return enc_i(6'h08, 0, 11, 16'd1);
      17: return enc_i(6'h08, 0, 11, 16'd2);
      18: return enc_i(6'h2b, 0, 31, 16'h0208);
      19: return enc_i(6'h3f, 1, 1, 16'h0000);
      20: return enc_r(2, 2, 1, 6'h3f);
      21: return enc_i(6'h2b, 0, 9, 16'h020C);
      22: return enc_i(6'h2b, 0, 10, 16'h0210);
      23: return enc_i(6'h2b, 0, 4, 16'h0214);
      24: return enc_i(6'h2b, 0, 7, 16'h0218);
      25: return enc_i(6'h2b, 0, 1, 16'h021C);
      26: return enc_i(6'h2b, 0, 2, 16'h0220);
      27: return enc_i(6'h2b, 0, 5, 16'h0224);
      28: return enc_i(6'h2b, 0, 6, 16'h0228);
      29: return enc_j(6'h02, 26'd29);
      default: return 32'h0;
    endcase
  endfunction

  // bench memory: single process owns it (preload then stores)
  initial begin
    for (int i = 0; i < 256; i++) mem[i] = prog_word(i);
    forever begin
      @(posedge clk);
      if (mem_wr) mem[mem_addr[9:2]] <= mem_wdata;
    end
  end
  assign mem_rdata = mem[mem_addr[9:2]];

  function automatic logic [31:0] sx(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction
  function automatic bit fn_ok(input logic [5:0] f);
    return (f == 6'h20) || (f == 6'h22) || (f == 6'h24) || (f == 6'h25) || (f == 6'h2a);
  endfunction
  function automatic int ilen(input logic [31:0] w);
    case (w[31:26])
      6'h23:        return 5;
      6'h2b, 6'h08: return 4;
      6'h00:        return fn_ok(w[5:0]) ? 4 : 2;
      6'h04, 6'h02, 6'h03: return 3;
      default:      return 2;
    endcase
  endfunction
  function automatic string itag(input logic [31:0] w);
    case (w[31:26])
      6'h23: return "R3/R4";
      6'h2b: return "R3/R5";
      6'h00: return fn_ok(w[5:0]) ? "R3/R6" : "R11";
      6'h08: return "R3/R7";
      6'h04: return "R3/R8";
      6'h02, 6'h03: return "R3/R9";
      default: return "R11";
    endcase
  endfunction

  task automatic retire(input logic [31:0] w);
    logic [31:0] npc, va, vb, imm, ea;
    npc = mpc + 32'd4;
    va  = mreg[w[25:21]];
    vb  = mreg[w[20:16]];
    imm = sx(w[15:0]);
    ea  = va + imm;
    mpc = npc;
    case (w[31:26])
      6'h00: if (fn_ok(w[5:0])) begin
        case (w[5:0])
          6'h20: mreg[w[15:11]] = va + vb;
          6'h22: mreg[w[15:11]] = va - vb;
          6'h24: mreg[w[15:11]] = va & vb;
          6'h25: mreg[w[15:11]] = va | vb;
          default: mreg[w[15:11]] = ($signed(va) < $signed(vb)) ? 32'd1 : 32'd0;
        endcase
      end
      6'h08: mreg[w[20:16]] = ea;
      6'h23: mreg[w[20:16]] = mmem[ea[9:2]];
      6'h04: if (va == vb) mpc = npc + {imm[29:0], 2'b00};
      6'h02: mpc = {npc[31:28], w[25:0], 2'b00};
      6'h03: begin
        mreg[31] = npc;
        mpc = {npc[31:28], w[25:0], 2'b00};
      end
      default: ;
    endcase
    mreg[0] = 32'd0;
  endtask

  task automatic step_check();
    logic        e_rd, e_wr;
    logic [31:0] e_addr, e_wdata, ea;
    string       tag;
    if (k == 0) begin
      cur      = mmem[mpc[9:2]];
      ilen_cur = ilen(cur);
    end
    ea      = mreg[cur[25:21]] + sx(cur[15:0]);
    e_rd    = 1'b0;
    e_wr    = 1'b0;
    e_addr  = 32'd0;
    e_wdata = 32'd0;
    tag     = itag(cur);
    if (k == 0) begin
      e_rd = 1'b1; e_addr = mpc; tag = "R2";
    end else if (k == 3 && cur[31:26] == 6'h23) begin
      e_rd = 1'b1; e_addr = ea;
    end else if (k == 3 && cur[31:26] == 6'h2b) begin
      e_wr = 1'b1; e_addr = ea; e_wdata = mreg[cur[20:16]];
    end
    n_tests++;
    if (mem_rd !== e_rd || mem_wr !== e_wr ||
        ((e_rd || e_wr) && mem_addr !== e_addr) ||
        (e_wr && mem_wdata !== e_wdata)) begin
      n_fail++;
      $display("FAIL %s pc=%h step=%0d: rd=%b wr=%b addr=%h wdata=%h expected rd=%b wr=%b addr=%h wdata=%h",
               tag, mpc, k, mem_rd, mem_wr, mem_addr, mem_wdata, e_rd, e_wr, e_addr, e_wdata);
    end
    if (e_wr) mmem[ea[9:2]] = e_wdata;
    k++;
    if (k == ilen_cur) begin
      retire(cur);
      k = 0;
    end
  endtask

  task automatic check_word(input int addr, input logic [31:0] exp, input string tag);
    n_tests++;
    if (mem[addr / 4] !== exp) begin
      n_fail++;
      $display("FAIL %s mem[%h]: actual %h expected %h", tag, addr, mem[addr / 4], exp);
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mmem[i] = prog_word(i);
    for (int i = 0; i < 32; i++) mreg[i] = 32'd0;
    mpc = 32'd0;
    k   = 0;
    #2 rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_tests++;  // R1: reset state
    if (mem_rd !== 1'b1 || mem_wr !== 1'b0 || mem_addr !== 32'd0) begin
      n_fail++;
      $display("FAIL R1 reset bus: rd=%b wr=%b addr=%h expected rd=1 wr=0 addr=00000000",
               mem_rd, mem_wr, mem_addr);
    end
    rst = 1'b0;
    #1;
    for (int c = 0; c < RUN_CYCLES; c++) begin
      step_check();
      @(negedge clk);
    end
    check_word(32'h200, 32'd4,        "R6 add");
    check_word(32'h204, 32'd0,        "R10 r0 write ignored");
    check_word(32'h208, 32'd64,       "R9 link value");
    check_word(32'h20C, 32'd4,        "R4 load result");
    check_word(32'h210, 32'd0,        "R8 taken branch skipped");
    check_word(32'h214, 32'hFFFFFFF6, "R6 sub");
    check_word(32'h218, 32'd1,        "R6 slt signed");
    check_word(32'h21C, 32'd7,        "R11 illegal no effect");
    check_word(32'h220, 32'hFFFFFFFD, "R7 addi negative");
    check_word(32'h224, 32'd5,        "R6 and");
    check_word(32'h228, 32'hFFFFFFFF, "R6 or");
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_fail++;
      $display("FAIL R2 watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule